// File: doc/BRIEF.md
# I2C Register Write Master

This block is a single-master I2C engine that performs one register transfer per request. On a start request it latches a 7-bit target address, a direction flag, a register index and a data byte. It then watches the bus until both wires have been high long enough to count as free. Once the bus is free it issues a start condition and shifts out the address byte, the register byte and, for writes, the data byte. Each byte goes out most significant bit first and is followed by a ninth clock for the acknowledge. The transfer ends with a stop condition.

Both bus wires are open-drain. The block has a pull-low enable per wire and reads the wire level back on its own input, so it never drives a line high. Three inputs set the timing, each counted in system clocks: the data setup time while SCL is low, the SCL high time, and the idle qualification time. The acknowledge returned by the target is clocked but not checked. A busy flag and a single-cycle completion pulse tell the requester where the transfer stands.

Top module: `i2c_reg_writer`

## Requirements
- R1: After reset, and whenever no transfer is running, both pull-low outputs are 0 (both lines released), `busy_o` is 0 and `done_o` is 0.
- R2: After a request, the start condition begins only once SCL and SDA have both been sampled high on `idle_cyc_i` consecutive clock edges. SDA is pulled low on the next edge. Any cycle in which either line is low restarts that count.
- R3: A transfer contains exactly one start condition: SDA falls while SCL is high, and no SCL rising edge comes before it. SCL is pulled low `high_cyc_i` cycles after SDA falls.
- R4: The first byte is `{addr_i[6:0], rnw_i}`, with the flag at bit 0 and 0 meaning write. The register byte follows, then the data byte. Every byte is sent MSB first, and a bit is sampled on each SCL rising edge.
- R5: After every 8 data bits, SDA is released for a ninth SCL pulse. The level the target puts on SDA in that slot has no effect on the bits, the timing or the completion of the transfer.
- R6: Within a transfer, SDA changes only while SCL is low, except for the one start condition and the one stop condition.
- R7: Each SCL high pulse lasts `high_cyc_i` clocks. Each SCL low interval before a rising edge lasts `setup_cyc_i` clocks, except the first one after the start, which lasts twice as long. A value of 0 behaves as 1.
- R8: A transfer ends with SCL released while SDA is still held low, then SDA released, leaving both lines high. No SCL rising edge follows.
- R9: When `rnw_i` is 1, only the address and register bytes (18 SCL pulses) are sent before the stop.
- R10: `busy_o` rises the cycle after an accepted request. On a free bus it stays high for 1 + 2·H + 2·S + N·(S+H) cycles, where N is 27 (write) or 18 (read). `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again.
- R11: A start request while `busy_o` is high is ignored. The bytes and timing of the running transfer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer request, taken when idle |
| addr_i | input | 7 | Target address |
| rnw_i | input | 1 | Direction flag, 1 = read request |
| reg_i | input | 8 | Register index byte |
| data_i | input | 8 | Data byte |
| setup_cyc_i | input | CW | SCL low time before a rising edge, in clocks |
| high_cyc_i | input | CW | SCL high time, in clocks |
| idle_cyc_i | input | IW | Edges with both lines high that qualify the bus as free |
| scl_i | input | 1 | Sampled SCL wire level |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps setup and high times, direction and acknowledge level. It rebuilds the bit stream from the modelled wires, so a byte-order slip, a missing acknowledge slot or a third byte on a read shows up as a wrong bit vector or a wrong pulse count. Illegal SDA movement while SCL is high looks to the bus monitor like an extra start or stop. A wrong first low interval, or an off-by-one in a phase counter, shows up as a pulse width or busy length that misses the arithmetic value. The bench also holds SCL low, and glitches it, while a request is pending. This catches an idle check that starts too early or does not restart its count. A second request injected mid-transfer shows whether fresh inputs are wrongly latched.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,   // waiting for a free bus
    ST_STA,    // SDA low, SCL high
    ST_STB,    // both low
    ST_SETUP,  // SCL low, data on SDA
    ST_HIGH,   // SCL released
    ST_STOA,   // both low before stop
    ST_STOB    // SCL released, SDA still low
  } i2cw_state_e;
endpackage

// File: rtl/i2cw_idle_mon.sv
module i2cw_idle_mon #(
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [IW-1:0] idle_cyc_i,
  output logic          idle_o
);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!(scl_i && sda_i))  cnt_q <= '0;
    else if (cnt_q < idle_cyc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign idle_o = scl_i && sda_i && (cnt_q >= idle_cyc_i);
endmodule

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // zero length acts as one
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i};
endmodule

// File: rtl/i2c_reg_writer.sv
module i2c_reg_writer
  import i2cw_pkg::*;
#(
  parameter int CW = 8,
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [6:0]    addr_i,
  input  logic          rnw_i,
  input  logic [7:0]    reg_i,
  input  logic [7:0]    data_i,
  input  logic [CW-1:0] setup_cyc_i,
  input  logic [CW-1:0] high_cyc_i,
  input  logic [IW-1:0] idle_cyc_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int         SLOT_BITS  = 9;
  localparam logic [3:0] LAST_BIT   = 4'(SLOT_BITS - 1);
  localparam logic [1:0] LAST_WRITE = 2'd2;
  localparam logic [1:0] LAST_READ  = 2'd1;

  i2cw_state_e          state_q;
  logic [SLOT_BITS-1:0] shreg_q;
  logic [3:0]           bit_q;
  logic [1:0]           byte_q;
  logic [7:0]           reg_q, data_q;
  logic                 rnw_q, done_q;
  logic                 idle_ok, last, timed, use_high, clear;
  logic [CW-1:0]        phase_len;
  logic [1:0]           final_byte;

  i2cw_idle_mon #(.IW(IW)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .idle_cyc_i (idle_cyc_i),
    .idle_o     (idle_ok)
  );

  assign timed     = !(state_q inside {ST_IDLE, ST_WAIT});
  assign use_high  = state_q inside {ST_STA, ST_HIGH, ST_STOB};
  assign phase_len = use_high ? high_cyc_i : setup_cyc_i;
  assign clear     = !timed || last;

  i2cw_phase_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .len_i   (phase_len),
    .last_o  (last)
  );

  assign final_byte = rnw_q ? LAST_READ : LAST_WRITE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      bit_q   <= '0;
      byte_q  <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      rnw_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          shreg_q <= {addr_i, rnw_i, 1'b1};
          reg_q   <= reg_i;
          data_q  <= data_i;
          rnw_q   <= rnw_i;
          bit_q   <= '0;
          byte_q  <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT:  if (idle_ok) state_q <= ST_STA;
        ST_STA:   if (last) state_q <= ST_STB;
        ST_STB:   if (last) state_q <= ST_SETUP;
        ST_SETUP: if (last) state_q <= ST_HIGH;
        ST_HIGH: if (last) begin
          if (bit_q != LAST_BIT) begin
            bit_q   <= bit_q + 1'b1;
            shreg_q <= {shreg_q[SLOT_BITS-2:0], 1'b1};  // 1 = release, gives ack slot
            state_q <= ST_SETUP;
          end else if (byte_q == final_byte) begin
            state_q <= ST_STOA;
          end else begin
            bit_q   <= '0;
            byte_q  <= byte_q + 1'b1;
            shreg_q <= {(byte_q == 2'd0) ? reg_q : data_q, 1'b1};
            state_q <= ST_SETUP;
          end
        end
        ST_STOA:  if (last) state_q <= ST_STOB;
        ST_STOB: if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_low_o = state_q inside {ST_STB, ST_SETUP, ST_STOA};
  assign sda_low_o = (state_q inside {ST_STA, ST_STB, ST_STOA, ST_STOB}) ||
                     ((state_q inside {ST_SETUP, ST_HIGH}) && !shreg_q[SLOT_BITS-1]);
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = done_q;
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic busy_o,
  input logic done_o
);
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !scl_low_o && !sda_low_o);

  a_r3_wait_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !scl_low_o && !sda_low_o);

  a_r6_sda_hold_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !scl_low_o && !$past(scl_low_o) |-> !$fell(sda_low_o));

  a_r8_stop_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(sda_low_o) && !$past(scl_low_o));

  a_r10_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind i2c_reg_writer i2cw_checker u_i2cw_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_i2c_reg_writer.sv
module tb_i2c_reg_writer;
  localparam int CW   = 4;
  localparam int IW   = 4;
  localparam int IDLE = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0, rnw = 1'b0;
  logic [6:0]    addr = '0;
  logic [7:0]    rg = '0, dat = '0;
  logic [CW-1:0] s_cyc = CW'(2), h_cyc = CW'(2);
  logic [IW-1:0] i_cyc = IW'(IDLE);
  logic          scl_low, sda_low, busy, done;
  logic          ext_scl_low = 1'b0, ack_low = 1'b0;
  logic          scl_w, sda_w;

  assign scl_w = !(scl_low || ext_scl_low);
  assign sda_w = !(sda_low || ack_low);

  i2c_reg_writer #(.CW(CW), .IW(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .rnw_i(rnw),
    .reg_i(rg), .data_i(dat), .setup_cyc_i(s_cyc), .high_cyc_i(h_cyc),
    .idle_cyc_i(i_cyc), .scl_i(scl_w), .sda_i(sda_w),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .busy_o(busy), .done_o(done)
  );

  int n_vec = 0, n_err = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor, sampled at negedge
  logic        p_scl = 1'b1, p_sda = 1'b1;
  logic [31:0] rx_bits;
  int rx_n, n_sta, n_sto, rises_pre, rises_post, bad_hi, bad_lo;
  int hi_len, lo_len, busy_len, done_len, done_busy, hi_run, hi_run_at_sta;
  int cur_s, cur_h;
  bit in_pulse, first_lo, seen_sta, seen_sto, ack_en;

  task automatic clear_mon();
    rx_bits = '0; rx_n = 0; n_sta = 0; n_sto = 0; rises_pre = 0; rises_post = 0;
    bad_hi = 0; bad_lo = 0; busy_len = 0; done_len = 0; done_busy = 0;
    in_pulse = 0; first_lo = 0; seen_sta = 0; seen_sto = 0; hi_run_at_sta = -1;
    ack_low = 1'b0;
  endtask

  always @(negedge clk) begin
    if (busy) busy_len++;
    if (done) begin done_len++; if (busy) done_busy++; end
    if (scl_w && p_scl && p_sda && !sda_w) begin
      n_sta++; seen_sta = 1; first_lo = 1; hi_run_at_sta = hi_run;
    end
    if (scl_w && p_scl && !p_sda && sda_w) begin
      n_sto++; seen_sto = 1; rx_n--; rx_bits = rx_bits >> 1;
    end
    if (scl_w && !p_scl) begin
      if (!seen_sta) rises_pre++;
      if (seen_sto) rises_post++;
      if (seen_sta && lo_len != (first_lo ? 2 * cur_s : cur_s)) bad_lo++;
      first_lo = 0;
      rx_bits = {rx_bits[30:0], sda_w};
      rx_n++; in_pulse = 1; hi_len = 0;
    end
    if (!scl_w && p_scl) begin
      if (in_pulse && hi_len != cur_h) bad_hi++;
      in_pulse = 0; lo_len = 0;
      if (ack_en && rx_n % 9 == 8) ack_low = 1'b1;
      else if (rx_n % 9 == 0) ack_low = 1'b0;
    end
    if (scl_w) hi_len++; else lo_len++;
    if (scl_w && sda_w) hi_run++; else hi_run = 0;
    p_scl = scl_w; p_sda = sda_w;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 4000 && done_len == 0; k++) tick(1);
  endtask

  task automatic run_xfer(input logic [6:0] a, input logic r, input logic [7:0] g,
                          input logic [7:0] d, input int s, input int h,
                          input bit ack, input bit poke);
    int nb, nbits;
    longint expv, ackbit, exp_busy;
    tick(1);
    addr = a; rnw = r; rg = g; dat = d;
    s_cyc = CW'(s); h_cyc = CW'(h); cur_s = s; cur_h = h;
    tick(IDLE + 3);
    clear_mon(); ack_en = ack;
    pulse_start();
    if (poke) begin
      tick(30);
      addr = ~a; rnw = ~r; rg = ~g; dat = ~d;
      pulse_start();
    end
    wait_done();
    tick(3);
    nb = r ? 2 : 3;
    nbits = nb * 9;
    ackbit = ack ? 0 : 1;
    expv = {a, r};
    expv = (expv << 1) | ackbit;
    expv = (expv << 9) | ({56'd0, g} << 1) | ackbit;
    if (!r) expv = (expv << 9) | ({56'd0, d} << 1) | ackbit;
    exp_busy = 1 + 2 * h + 2 * s + nbits * (s + h);
    chk(poke ? "R11" : "R4", "bit stream", longint'(rx_bits) & ((64'd1 << nbits) - 1), expv);
    chk(r ? "R9" : "R4", "scl pulses", rx_n, nbits);
    for (int j = 0; j < nb; j++)
      chk("R5", "ack slot level", rx_bits[j * 9], ackbit);
    chk("R3", "start count", n_sta, 1);
    chk("R3", "rises before start", rises_pre, 0);
    chk("R6", "start+stop events", n_sta + n_sto, 2);
    chk("R8", "stop count", n_sto, 1);
    chk("R8", "rises after stop", rises_post, 0);
    chk("R8", "lines released", {scl_w, sda_w}, 2'b11);
    chk("R7", "bad high widths", bad_hi, 0);
    chk("R7", "bad low widths", bad_lo, 0);
    chk(poke ? "R11" : "R10", "busy length", busy_len, exp_busy);
    chk("R10", "done cycles", done_len, 1);
    chk("R10", "done while busy", done_busy, 0);
  endtask

  task automatic busy_bus(input bit glitch);
    tick(1);
    addr = 7'h21; rnw = 1'b1; rg = 8'h3C; s_cyc = CW'(1); h_cyc = CW'(1);
    cur_s = 1; cur_h = 1;
    ext_scl_low = 1'b1;
    tick(2);
    clear_mon(); ack_en = 0;
    pulse_start();
    tick(20);
    chk("R2", "start while bus held", n_sta, 0);
    chk("R2", "busy while waiting", busy, 1);
    ext_scl_low = 1'b0;
    if (glitch) begin
      tick(3); ext_scl_low = 1'b1; tick(1); ext_scl_low = 1'b0;
    end
    wait_done();
    tick(3);
    chk("R2", "high samples before start", hi_run_at_sta, IDLE + 1);
    chk("R2", "transfer completed", done_len, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int k;
    clear_mon();
    cur_s = 2; cur_h = 2; hi_len = 0; lo_len = 0; hi_run = 0;
    tick(3);
    chk("R1", "reset outputs", {scl_low, sda_low, busy, done}, 4'b0000);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "idle outputs", {scl_low, sda_low, busy, done}, 4'b0000);
    k = 0;
    for (int s = 1; s <= 3; s++)
      for (int h = 1; h <= 3; h++)
        for (int r = 0; r < 2; r++)
          for (int a = 0; a < 2; a++) begin
            run_xfer(7'(7'h5A + k * 13), r[0], 8'(k * 37 + 1), 8'(~(k * 53)), s, h, a[0], 0);
            k++;
          end
    run_xfer(7'h7F, 1'b0, 8'hFF, 8'hFF, 2, 2, 0, 0);
    run_xfer(7'h00, 1'b0, 8'h00, 8'h00, 2, 2, 1, 0);
    run_xfer(7'h55, 1'b0, 8'hAA, 8'h55, 1, 2, 1, 0);
    run_xfer(7'h12, 1'b0, 8'h34, 8'h56, 2, 1, 0, 1);
    run_xfer(7'h6B, 1'b1, 8'hC3, 8'h99, 3, 3, 1, 1);
    busy_bus(0);
    busy_bus(1);
    tick(4);
    chk("R1", "idle after all", {scl_low, sda_low, busy, done}, 4'b0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule